// File: doc/BRIEF.md
# Key-Deployment Engine Control Register Bank

This block is the software-facing register bank of a key-deployment engine. It sits on a simple 32-bit read/write bus with combinational read data, and holds the engine's static configuration, its operating configuration, clock force-on controls and a small interrupt unit. Each static configuration field can be frozen by a lock bit. Software can set a lock bit but cannot clear it. Once a field is locked, bus writes to it are dropped until the next reset.

Three done events from the engine (preparation, processing, post-processing) each latch a raw interrupt bit. A raw bit stays set until software writes 1 to the matching bit of the clear register. Each source is masked by an enable bit, and the interrupt line is the OR of the masked bits. Engine state, result, per-key valid flags and the root-key valid flag come in on ports and can be read back unchanged. Writes to the command register give one-cycle launch and proceed pulses to the engine.

Top module: `km_reg_bank`

## Requirements
- R1: Reset values: clock-gate 0x04 = 0x1, raw 0x08 = 0, enable 0x10 = 0, static 0x18 = 0x1E0 (sample count 15), lock 0x1C = 0, config 0x20 = 0, version 0xFC = 0x02312150. irq_o and both command pulses are 0.
- R2: Static register 0x18 fields: [4:0] use-fused-key per key type, [9:5] RNG sample-cycle count, bit 10 software-init-key select, bit 11 flash 256-bit length, bit 12 psram 256-bit length. Bits 31:13 read 0. The fields drive the matching output ports.
- R3: Lock register 0x1C is write-1-to-set. Writing 0 clears nothing. Only bits [8:0] exist.
- R4: Lock bit k (k = 0..4) freezes use-fused bit k. Lock bit 5 freezes the sample count, bit 6 the init-key select, bit 7 the flash length and bit 8 the psram length. Unlocked bits in the same write still update.
- R5: A done pulse on done_evt_i[k] sets raw bit k (0x08, bits 0..2) on the next clock. Writing 1 to bit k of clear register 0x14 clears it.
- R6: Status 0x0C reads raw AND enable. irq_o is 1 when any status bit is 1.
- R7: If a done pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: Unmapped offsets, the clear register and the command register read 0. Writes to raw, status, state, result and valid registers change nothing.
- R9: 0x28 reads eng_state_i in [1:0], 0x2C reads eng_result_i, 0x30 reads key_vld_i in [4:0] and 0x34 reads root_key_vld_i, all as the current input values.
- R10: Writing 0x24 with bit 0 set gives a one-cycle pulse on cmd_proceed_o, and with bit 1 set a one-cycle pulse on cmd_launch_o, in the cycle after the write.
- R11: Config 0x20 holds generation mode in [2:0] and key purpose in [6:3]. Clock-gate 0x04 holds register clock force-on in bit 0 and memory clock force-on in bit 1. All of these are read/write and drive their output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| done_evt_i | input | 3 | Done pulses: bit0 prep, bit1 proc, bit2 post |
| eng_state_i | input | 2 | Engine state |
| eng_result_i | input | 1 | Engine procedure result |
| key_vld_i | input | 5 | Per-key deployed flags |
| root_key_vld_i | input | 1 | Root key valid flag |
| use_fused_o | output | 5 | Use-fused-key selects |
| sample_cyc_o | output | 5 | RNG sample-cycle count |
| sw_init_sel_o | output | 1 | Software init key select |
| flash_len256_o | output | 1 | Flash key 256-bit |
| psram_len256_o | output | 1 | Psram key 256-bit |
| gen_mode_o | output | 3 | Generation mode |
| purpose_o | output | 4 | Key purpose |
| reg_clk_on_o | output | 1 | Register clock force-on |
| mem_clk_on_o | output | 1 | Memory clock force-on |
| cmd_proceed_o | output | 1 | Proceed pulse |
| cmd_launch_o | output | 1 | Launch pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
A lock bit that drops wrongly shows up on the next read of 0x1C, and on the following static write as a field that changes when it should hold. A stuck or early-cleared raw bit is visible at 0x08 and on irq_o one clock after the event or clear write. A wrong set/clear priority only shows in the cycle where the two collide, so that case is driven on purpose. A command pulse that lasts too long is caught by checking cmd outputs one clock after the write and again one clock later.

// File: rtl/km_regs_pkg.sv
package km_regs_pkg;

    localparam int KEY_N   = 5;
    localparam int CYC_W   = 5;
    localparam int MODE_W  = 3;
    localparam int PURP_W  = 4;
    localparam int IRQ_N   = 3;
    localparam int STATE_W = 2;
    localparam int VER_W   = 28;
    localparam int CMD_W   = 2;
    localparam int CLK_W   = 2;

    localparam int SWI_BIT = KEY_N + CYC_W;
    localparam int STAT_W  = SWI_BIT + 3;
    localparam int LK_CYC  = KEY_N;
    localparam int LK_SWI  = KEY_N + 1;
    localparam int LK_FLN  = KEY_N + 2;
    localparam int LK_PLN  = KEY_N + 3;
    localparam int LOCK_W  = KEY_N + 4;
    localparam int CONF_W  = MODE_W + PURP_W;

    localparam int OFF_CLK  = 'h04;
    localparam int OFF_RAW  = 'h08;
    localparam int OFF_STS  = 'h0C;
    localparam int OFF_ENA  = 'h10;
    localparam int OFF_CLR  = 'h14;
    localparam int OFF_STAT = 'h18;
    localparam int OFF_LOCK = 'h1C;
    localparam int OFF_CONF = 'h20;
    localparam int OFF_CMD  = 'h24;
    localparam int OFF_STE  = 'h28;
    localparam int OFF_RES  = 'h2C;
    localparam int OFF_KEYV = 'h30;
    localparam int OFF_ROOT = 'h34;
    localparam int OFF_VER  = 'hFC;

    // Packed from MSB down so the struct equals the register bit layout
    typedef struct packed {
        logic             psram_len;
        logic             flash_len;
        logic             sw_init;
        logic [CYC_W-1:0] cyc;
        logic [KEY_N-1:0] fused;
    } static_cfg_t;

endpackage

// File: rtl/km_cfg_lock.sv
module km_cfg_lock
    import km_regs_pkg::*;
#(
    parameter logic [CYC_W-1:0] CYC_RST = 5'd15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat_i,
    input  logic              wr_lock_i,
    input  logic              wr_conf_i,
    input  logic              wr_clk_i,
    input  logic [STAT_W-1:0] wdata_i,
    output static_cfg_t       stat_o,
    output logic [LOCK_W-1:0] lock_o,
    output logic [CONF_W-1:0] conf_o,
    output logic [CLK_W-1:0]  clk_on_o
);

    typedef struct packed {
        static_cfg_t       stat;
        logic [LOCK_W-1:0] lock;
        logic [CONF_W-1:0] conf;
        logic [CLK_W-1:0]  clk_on;
    } cfg_state_t;

    cfg_state_t  cur_q, nxt_d;
    static_cfg_t req;

    assign req = static_cfg_t'(wdata_i);

    always_comb begin
        nxt_d = cur_q;
        if (wr_lock_i) begin
            nxt_d.lock = cur_q.lock | wdata_i[LOCK_W-1:0];
        end
        if (wr_stat_i) begin
            for (int k = 0; k < KEY_N; k++) begin
                if (!cur_q.lock[k]) nxt_d.stat.fused[k] = req.fused[k];
            end
            if (!cur_q.lock[LK_CYC]) nxt_d.stat.cyc       = req.cyc;
            if (!cur_q.lock[LK_SWI]) nxt_d.stat.sw_init   = req.sw_init;
            if (!cur_q.lock[LK_FLN]) nxt_d.stat.flash_len = req.flash_len;
            if (!cur_q.lock[LK_PLN]) nxt_d.stat.psram_len = req.psram_len;
        end
        if (wr_conf_i) nxt_d.conf   = wdata_i[CONF_W-1:0];
        if (wr_clk_i)  nxt_d.clk_on = wdata_i[CLK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.stat.psram_len <= 1'b0;
            cur_q.stat.flash_len <= 1'b0;
            cur_q.stat.sw_init   <= 1'b0;
            cur_q.stat.cyc       <= CYC_RST;
            cur_q.stat.fused     <= '0;
            cur_q.lock           <= '0;
            cur_q.conf           <= '0;
            cur_q.clk_on         <= CLK_W'(1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stat_o   = cur_q.stat;
    assign lock_o   = cur_q.lock;
    assign conf_o   = cur_q.conf;
    assign clk_on_o = cur_q.clk_on;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.lock != '0) |=> ((cur_q.lock & $past(cur_q.lock)) == $past(cur_q.lock))); // R3

    AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.lock[LK_CYC] |=> $stable(cur_q.stat.cyc)); // R4

    AST_PSRAM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.lock[LK_PLN] |=> $stable(cur_q.stat.psram_len)); // R4

endmodule

// File: rtl/km_irq_bank.sv
module km_irq_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_wr_i,
    input  logic         ena_wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] ena_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] ena;
    } irq_state_t;

    irq_state_t   cur_q, nxt_d;
    logic [N-1:0] raw_nxt;

    for (genvar g = 0; g < N; g++) begin : g_src
        // set has priority over a clear landing in the same cycle
        assign raw_nxt[g] = evt_i[g] | (cur_q.raw[g] & ~(clr_wr_i & wdata_i[g]));

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> cur_q.raw[g]); // R7

        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && wdata_i[g] && !evt_i[g]) |=> !cur_q.raw[g]); // R5
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.raw = raw_nxt;
        if (ena_wr_i) nxt_d.ena = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign raw_o = cur_q.raw;
    assign ena_o = cur_q.ena;
    assign irq_o = |(cur_q.raw & cur_q.ena);

endmodule

// File: rtl/km_rd_mux.sv
module km_rd_mux
    import km_regs_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter int               DATA_W  = 32,
    parameter logic [VER_W-1:0] VERSION = 28'd36774224
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [CLK_W-1:0]   clk_on_i,
    input  logic [IRQ_N-1:0]   raw_i,
    input  logic [IRQ_N-1:0]   ena_i,
    input  static_cfg_t        stat_i,
    input  logic [LOCK_W-1:0]  lock_i,
    input  logic [CONF_W-1:0]  conf_i,
    input  logic [STATE_W-1:0] state_i,
    input  logic               result_i,
    input  logic [KEY_N-1:0]   keyv_i,
    input  logic               root_i,
    output logic [DATA_W-1:0]  rdata_o
);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFF_CLK):  rdata_o[CLK_W-1:0]   = clk_on_i;
            ADDR_W'(OFF_RAW):  rdata_o[IRQ_N-1:0]   = raw_i;
            ADDR_W'(OFF_STS):  rdata_o[IRQ_N-1:0]   = raw_i & ena_i;
            ADDR_W'(OFF_ENA):  rdata_o[IRQ_N-1:0]   = ena_i;
            ADDR_W'(OFF_STAT): rdata_o[STAT_W-1:0]  = stat_i;
            ADDR_W'(OFF_LOCK): rdata_o[LOCK_W-1:0]  = lock_i;
            ADDR_W'(OFF_CONF): rdata_o[CONF_W-1:0]  = conf_i;
            ADDR_W'(OFF_STE):  rdata_o[STATE_W-1:0] = state_i;
            ADDR_W'(OFF_RES):  rdata_o[0]           = result_i;
            ADDR_W'(OFF_KEYV): rdata_o[KEY_N-1:0]   = keyv_i;
            ADDR_W'(OFF_ROOT): rdata_o[0]           = root_i;
            ADDR_W'(OFF_VER):  rdata_o[VER_W-1:0]   = VERSION;
            default:           rdata_o              = '0;
        endcase
    end

endmodule

// File: rtl/km_reg_bank.sv
module km_reg_bank
    import km_regs_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter int               DATA_W  = 32,
    parameter logic [CYC_W-1:0] CYC_RST = 5'd15,
    parameter logic [VER_W-1:0] VERSION = 28'd36774224
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [IRQ_N-1:0]   done_evt_i,
    input  logic [STATE_W-1:0] eng_state_i,
    input  logic               eng_result_i,
    input  logic [KEY_N-1:0]   key_vld_i,
    input  logic               root_key_vld_i,
    output logic [KEY_N-1:0]   use_fused_o,
    output logic [CYC_W-1:0]   sample_cyc_o,
    output logic               sw_init_sel_o,
    output logic               flash_len256_o,
    output logic               psram_len256_o,
    output logic [MODE_W-1:0]  gen_mode_o,
    output logic [PURP_W-1:0]  purpose_o,
    output logic               reg_clk_on_o,
    output logic               mem_clk_on_o,
    output logic               cmd_proceed_o,
    output logic               cmd_launch_o,
    output logic               irq_o
);

    logic wr;
    logic wr_clk, wr_ena, wr_clr, wr_stat, wr_lock, wr_conf, wr_cmd;

    assign wr      = bus_en & bus_we;
    assign wr_clk  = wr && (bus_addr == ADDR_W'(OFF_CLK));
    assign wr_ena  = wr && (bus_addr == ADDR_W'(OFF_ENA));
    assign wr_clr  = wr && (bus_addr == ADDR_W'(OFF_CLR));
    assign wr_stat = wr && (bus_addr == ADDR_W'(OFF_STAT));
    assign wr_lock = wr && (bus_addr == ADDR_W'(OFF_LOCK));
    assign wr_conf = wr && (bus_addr == ADDR_W'(OFF_CONF));
    assign wr_cmd  = wr && (bus_addr == ADDR_W'(OFF_CMD));

    wire unused_wdata = ^bus_wdata[DATA_W-1:STAT_W];

    static_cfg_t       stat;
    logic [LOCK_W-1:0] lock;
    logic [CONF_W-1:0] conf;
    logic [CLK_W-1:0]  clk_on;
    logic [IRQ_N-1:0]  raw, ena;

    km_cfg_lock #(
        .CYC_RST (CYC_RST)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stat_i (wr_stat),
        .wr_lock_i (wr_lock),
        .wr_conf_i (wr_conf),
        .wr_clk_i  (wr_clk),
        .wdata_i   (bus_wdata[STAT_W-1:0]),
        .stat_o    (stat),
        .lock_o    (lock),
        .conf_o    (conf),
        .clk_on_o  (clk_on)
    );

    km_irq_bank #(
        .N (IRQ_N)
    ) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (done_evt_i),
        .clr_wr_i (wr_clr),
        .ena_wr_i (wr_ena),
        .wdata_i  (bus_wdata[IRQ_N-1:0]),
        .raw_o    (raw),
        .ena_o    (ena),
        .irq_o    (irq_o)
    );

    km_rd_mux #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .VERSION (VERSION)
    ) rd_i (
        .addr_i   (bus_addr),
        .clk_on_i (clk_on),
        .raw_i    (raw),
        .ena_i    (ena),
        .stat_i   (stat),
        .lock_i   (lock),
        .conf_i   (conf),
        .state_i  (eng_state_i),
        .result_i (eng_result_i),
        .keyv_i   (key_vld_i),
        .root_i   (root_key_vld_i),
        .rdata_o  (bus_rdata)
    );

    // command pulses: bit0 proceed, bit1 launch
    logic [CMD_W-1:0] cmd_d, cmd_q;

    always_comb begin
        cmd_d = '0;
        if (wr_cmd) cmd_d = bus_wdata[CMD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign cmd_proceed_o  = cmd_q[0];
    assign cmd_launch_o   = cmd_q[1];
    assign use_fused_o    = stat.fused;
    assign sample_cyc_o   = stat.cyc;
    assign sw_init_sel_o  = stat.sw_init;
    assign flash_len256_o = stat.flash_len;
    assign psram_len256_o = stat.psram_len;
    assign gen_mode_o     = conf[MODE_W-1:0];
    assign purpose_o      = conf[CONF_W-1:MODE_W];
    assign reg_clk_on_o   = clk_on[0];
    assign mem_clk_on_o   = clk_on[1];

    AST_PROCEED_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_proceed_o |-> $past(wr_cmd && bus_wdata[0])); // R10

    AST_LAUNCH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_launch_o |-> $past(wr_cmd && bus_wdata[1])); // R10

endmodule

// File: tb/km_reg_bank_tb_top.sv
`timescale 1ns/1ps
module km_reg_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [2:0]  done_evt_i;
    logic [1:0]  eng_state_i;
    logic        eng_result_i;
    logic [4:0]  key_vld_i;
    logic        root_key_vld_i;
    logic [4:0]  use_fused_o, sample_cyc_o;
    logic        sw_init_sel_o, flash_len256_o, psram_len256_o;
    logic [2:0]  gen_mode_o;
    logic [3:0]  purpose_o;
    logic        reg_clk_on_o, mem_clk_on_o, cmd_proceed_o, cmd_launch_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    km_reg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_evt_i(done_evt_i), .eng_state_i(eng_state_i),
        .eng_result_i(eng_result_i), .key_vld_i(key_vld_i),
        .root_key_vld_i(root_key_vld_i), .use_fused_o(use_fused_o),
        .sample_cyc_o(sample_cyc_o), .sw_init_sel_o(sw_init_sel_o),
        .flash_len256_o(flash_len256_o), .psram_len256_o(psram_len256_o),
        .gen_mode_o(gen_mode_o), .purpose_o(purpose_o),
        .reg_clk_on_o(reg_clk_on_o), .mem_clk_on_o(mem_clk_on_o),
        .cmd_proceed_o(cmd_proceed_o), .cmd_launch_o(cmd_launch_o),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;  // write data, or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h18, 32'h0000_1FFF, 4'd2},   // R2 all fields set
        '{1'b0, 8'h18, 32'h0000_1FFF, 4'd2},
        '{1'b1, 8'h18, 32'hFFFF_EA25, 4'd2},   // R2 mixed, upper bits dropped
        '{1'b0, 8'h18, 32'h0000_0A25, 4'd2},
        '{1'b1, 8'h20, 32'h0000_007F, 4'd11},  // R11
        '{1'b0, 8'h20, 32'h0000_007F, 4'd11},
        '{1'b1, 8'h20, 32'hFFFF_FF95, 4'd11},
        '{1'b0, 8'h20, 32'h0000_0015, 4'd11},
        '{1'b1, 8'h04, 32'h0000_0002, 4'd11},
        '{1'b0, 8'h04, 32'h0000_0002, 4'd11},
        '{1'b1, 8'h10, 32'h0000_0005, 4'd6},   // R6 enable
        '{1'b0, 8'h10, 32'h0000_0005, 4'd6},
        '{1'b1, 8'h08, 32'h0000_0007, 4'd8},   // R8 raw is read-only
        '{1'b0, 8'h08, 32'h0000_0000, 4'd8},
        '{1'b1, 8'h28, 32'h0000_0003, 4'd8},   // R8 state is read-only
        '{1'b0, 8'h28, 32'h0000_0002, 4'd8},
        '{1'b0, 8'h40, 32'h0000_0000, 4'd8},   // R8 unmapped
        '{1'b0, 8'hF8, 32'h0000_0000, 4'd8}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        done_evt_i = m;
        @(negedge clk);
        done_evt_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        done_evt_i = '0; eng_state_i = 2'd2; eng_result_i = 1'b1;
        key_vld_i = 5'b10110; root_key_vld_i = 1'b1;
        do_reset();

        // R1 reset state
        rd(8'h04, 32'h1, "R1 clkgate");
        rd(8'h08, 32'h0, "R1 raw");
        rd(8'h10, 32'h0, "R1 enable");
        rd(8'h18, 32'h1E0, "R1 static");
        rd(8'h1C, 32'h0, "R1 lock");
        rd(8'h20, 32'h0, "R1 config");
        rd(8'hFC, 32'h0231_2150, "R1 version");
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 cmd", {30'b0, cmd_launch_o, cmd_proceed_o}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
            else rd(TBL[i].addr, TBL[i].data, $sformatf("R%0d table[%0d]", TBL[i].req, i));
        end

        // R2 / R11 output ports after table
        chk("R2 fused port", {27'b0, use_fused_o}, 32'h5);
        chk("R2 cyc port", {27'b0, sample_cyc_o}, 32'd17);
        chk("R2 len ports", {29'b0, psram_len256_o, flash_len256_o, sw_init_sel_o}, 32'h2);
        chk("R11 mode/purpose", {25'b0, purpose_o, gen_mode_o}, 32'h15);
        chk("R11 clk ports", {30'b0, mem_clk_on_o, reg_clk_on_o}, 32'h2);

        // R3 / R4 locking
        wr(8'h18, 32'h0);
        rd(8'h18, 32'h0, "R2 cleared");
        wr(8'h1C, 32'h21);
        rd(8'h1C, 32'h21, "R3 set bits");
        wr(8'h1C, 32'h0);
        rd(8'h1C, 32'h21, "R3 zero write keeps");
        wr(8'h18, 32'h1FFF);
        rd(8'h18, 32'h1C1E, "R4 partial lock");
        chk("R4 cyc port frozen", {27'b0, sample_cyc_o}, 32'h0);
        wr(8'h1C, 32'h1C0);
        rd(8'h1C, 32'h1E1, "R3 accumulate");
        wr(8'h18, 32'h0);
        rd(8'h18, 32'h1C00, "R4 lengths frozen");
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h1FF, "R3 width");
        wr(8'h18, 32'h1FFF);
        rd(8'h18, 32'h1C00, "R4 all locked");

        // R5 / R6 / R7 interrupts (enable = 0x5)
        pulse(3'b010);
        rd(8'h08, 32'h2, "R5 raw set");
        rd(8'h0C, 32'h0, "R6 masked");
        chk("R6 irq masked", {31'b0, irq_o}, 32'h0);
        pulse(3'b001);
        rd(8'h08, 32'h3, "R5 raw two");
        rd(8'h0C, 32'h1, "R6 status");
        chk("R6 irq on", {31'b0, irq_o}, 32'h1);
        wr(8'h14, 32'h1);
        rd(8'h08, 32'h2, "R5 clear");
        chk("R6 irq off", {31'b0, irq_o}, 32'h0);
        rd(8'h14, 32'h0, "R8 clear reads 0");
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h2; done_evt_i = 3'b010;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0; done_evt_i = '0;
        rd(8'h08, 32'h2, "R7 set wins");
        wr(8'h14, 32'h2);
        rd(8'h08, 32'h0, "R5 clear second");
        wr(8'h10, 32'h4);
        pulse(3'b100);
        rd(8'h0C, 32'h4, "R6 post status");
        chk("R6 irq post", {31'b0, irq_o}, 32'h1);

        // R9 status views
        rd(8'h28, 32'h2, "R9 state");
        rd(8'h2C, 32'h1, "R9 result");
        rd(8'h30, 32'h16, "R9 keyvld");
        rd(8'h34, 32'h1, "R9 root");
        eng_state_i = 2'd1; key_vld_i = 5'b01001; root_key_vld_i = 1'b0;
        rd(8'h28, 32'h1, "R9 state follows");
        rd(8'h30, 32'h9, "R9 keyvld follows");
        rd(8'h34, 32'h0, "R9 root follows");

        // R10 command pulses
        wr(8'h24, 32'h2);
        #1;
        chk("R10 launch pulse", {30'b0, cmd_launch_o, cmd_proceed_o}, 32'h2);
        @(negedge clk); #1;
        chk("R10 launch ends", {30'b0, cmd_launch_o, cmd_proceed_o}, 32'h0);
        wr(8'h24, 32'h1);
        #1;
        chk("R10 proceed pulse", {30'b0, cmd_launch_o, cmd_proceed_o}, 32'h1);
        @(negedge clk); #1;
        chk("R10 proceed ends", {30'b0, cmd_launch_o, cmd_proceed_o}, 32'h0);
        rd(8'h24, 32'h0, "R8 cmd reads 0");

        // R1 reset mid-run
        do_reset();
        rd(8'h1C, 32'h0, "R1 lock after reset");
        rd(8'h18, 32'h1E0, "R1 static after reset");
        rd(8'h08, 32'h0, "R1 raw after reset");
        rd(8'h04, 32'h1, "R1 clkgate after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule